// File: doc/BRIEF.md
# Filtered Edge Capture Unit

This block timestamps edges on an external input. The raw input is first brought into the module clock domain by a two-flop synchronizer. It then passes through a minimum-pulse-width filter, also clocked by the module clock. The filtered level is compared with its previous value. When it changes in a direction selected by configuration, the current value of a timebase counter is stored in a single capture register, and a sticky event flag is set.

The timebase can come from a local counter or from a shared counter bus. A timebase that feeds this capture unit must not drive pulse-width generation at the same time. Only the most recent event is kept. A later event overwrites the stored value, even while the flag from an earlier event is still set. Software clears the flag by pulsing a clear strobe.

The filter width is chosen from a small set of powers of two, and one setting bypasses it. In bypass, a level change at the pin reaches the filtered output after three clock edges. Each doubling of the width adds the matching number of edges.

Top module: `pulse_capture_unit`

## Requirements
- R1: While reset is asserted and after its release with no input activity, `filt_o`, `cap_flag_o` and `cap_val_o` are all zero.
- R2: With `filt_sel_i` = 0 (bypass), `filt_o` equals the level of `pin_i` sampled at the third rising edge before the current one. A change therefore appears on the third rising edge, counting the first edge that samples the new level.
- R3: `filt_sel_i` codes 1, 2, 3 and 4 select a width W of 2, 4, 8 and 16 cycles. Codes 5 to 7 behave as 16, and code 0 behaves as W = 1. A new pin level sampled on W consecutive rising edges reaches `filt_o` on edge W+2, counting the first of those edges.
- R4: A pin level that is sampled on fewer than W consecutive edges before reverting never changes `filt_o`.
- R5: `edge_sel_i` bit 0 enables capture on a low-to-high change of `filt_o`, and bit 1 enables capture on a high-to-low change. On an enabled change, `cap_val_o` takes the value of `tbase_i` present at the same clock edge on which `filt_o` changes. Both outputs update together.
- R6: A change of `filt_o` whose direction is not enabled by `edge_sel_i` leaves `cap_val_o` and `cap_flag_o` unchanged. With `edge_sel_i` = 0, capture is disabled entirely.
- R7: `cap_flag_o` is set by every capture and stays set until a cycle with `flag_clr_i` high, after which it reads 0. If a capture and a clear fall on the same edge, the flag stays set.
- R8: A capture while `cap_flag_o` is already set still replaces `cap_val_o` with the new timebase value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; also clocks the filter |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous input pin |
| tbase_i | input | TB_W | Timebase count value to be captured |
| filt_sel_i | input | 3 | Filter width code (0 bypass, 1..4 widths 2..16) |
| edge_sel_i | input | 2 | Bit 0 rising capture enable, bit 1 falling capture enable |
| flag_clr_i | input | 1 | Clear strobe for the event flag |
| cap_val_o | output | TB_W | Timebase value stored at the latest event |
| cap_flag_o | output | 1 | Sticky capture event flag |
| filt_o | output | 1 | Synchronized and filtered input level |

## Verification
The assertions assume that `filt_sel_i` does not change while a new level is partway through qualification. The bypass latency property only checks cycles in which the bypass code was applied at the relevant edge. Capture checks take the edge selection as it stood on the edge where the filtered level moved. The stimulus changes the width code only after the pin has been held steady for longer than the widest window, so the qualification counter is idle at each switch. Edge selection, clear strobes and timebase values are otherwise random on every cycle.

// File: rtl/capt_pkg.sv
`timescale 1ns/1ps
package capt_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    // Width in cycles for a filter code; codes above log_max saturate.
    function automatic int unsigned filt_width(input logic [2:0] sel,
                                               input int unsigned log_max);
        int unsigned s;
        s = int'(sel);
        if (s >= log_max) return 32'd1 << log_max;
        return 32'd1 << s;
    endfunction

endpackage

// File: rtl/capt_sync.sv
`timescale 1ns/1ps
module capt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/capt_glitch_filter.sv
`timescale 1ns/1ps
module capt_glitch_filter
    import capt_pkg::*;
#(
    parameter int unsigned LOG_MAX = 4,
    localparam int unsigned CNT_W  = LOG_MAX + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [2:0] sel_i,
    output logic       lvl_o,
    output logic       upd_o,
    output logic       lvl_next_o
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(filt_width(sel_i, LOG_MAX) - 1);
        st_d  = st_q;
        upd_o = 1'b0;
        if (sync_i != st_q.lvl) begin
            if (st_q.cnt >= limit) begin
                st_d.lvl = sync_i;
                st_d.cnt = '0;
                upd_o    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o      = st_q.lvl;
    assign lvl_next_o = st_d.lvl;
endmodule

// File: rtl/capt_event_reg.sv
`timescale 1ns/1ps
module capt_event_reg
    import capt_pkg::*;
#(
    parameter int unsigned TB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            upd_i,
    input  logic            lvl_next_i,
    input  logic [1:0]      edge_sel_i,
    input  logic [TB_W-1:0] tbase_i,
    input  logic            clr_i,
    output logic [TB_W-1:0] val_o,
    output logic            flag_o
);
    typedef struct packed {
        logic [TB_W-1:0] val;
        logic            flag;
    } evt_st_t;

    evt_st_t    st_d, st_q;
    edge_mode_e mode;
    logic       hit;

    always_comb begin
        mode = edge_mode_e'(edge_sel_i);
        hit  = upd_i && ((lvl_next_i  && (mode == EDGE_RISE || mode == EDGE_BOTH)) ||
                         (!lvl_next_i && (mode == EDGE_FALL || mode == EDGE_BOTH)));
        st_d = st_q;
        if (hit) begin
            st_d.val  = tbase_i;
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o  = st_q.val;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/pulse_capture_unit.sv
`timescale 1ns/1ps
module pulse_capture_unit #(
    parameter int unsigned TB_W        = 16,
    parameter int unsigned FILT_LOGMAX = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_i,
    input  logic [TB_W-1:0] tbase_i,
    input  logic [2:0]      filt_sel_i,
    input  logic [1:0]      edge_sel_i,
    input  logic            flag_clr_i,
    output logic [TB_W-1:0] cap_val_o,
    output logic            cap_flag_o,
    output logic            filt_o
);
    logic pin_sync, lvl_upd, lvl_next;

    capt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_i), .sync_o(pin_sync)
    );

    capt_glitch_filter #(.LOG_MAX(FILT_LOGMAX)) u_filt (
        .clk(clk), .rst_n(rst_n), .sync_i(pin_sync), .sel_i(filt_sel_i),
        .lvl_o(filt_o), .upd_o(lvl_upd), .lvl_next_o(lvl_next)
    );

    capt_event_reg #(.TB_W(TB_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .upd_i(lvl_upd), .lvl_next_i(lvl_next),
        .edge_sel_i(edge_sel_i), .tbase_i(tbase_i), .clr_i(flag_clr_i),
        .val_o(cap_val_o), .flag_o(cap_flag_o)
    );
endmodule

// File: rtl/capt_checker.sv
`timescale 1ns/1ps
module capt_checker #(
    parameter int unsigned TB_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pin_i,
    input logic [TB_W-1:0] tbase_i,
    input logic [2:0]      filt_sel_i,
    input logic [1:0]      edge_sel_i,
    input logic            flag_clr_i,
    input logic [TB_W-1:0] cap_val_o,
    input logic            cap_flag_o,
    input logic            filt_o
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    assert_bypass_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3 && $past(filt_sel_i) == 3'd0) |-> filt_o == $past(pin_i, 3));

    assert_rise_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(filt_o) && $past(edge_sel_i[0])) |-> (cap_flag_o && cap_val_o == $past(tbase_i)));

    assert_fall_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(filt_o) && $past(edge_sel_i[1])) |-> (cap_flag_o && cap_val_o == $past(tbase_i)));

    assert_value_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val_o) |-> !$stable(filt_o));

    assert_flag_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag_o) |-> !$stable(filt_o));

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_clr_i) && $stable(filt_o)) |-> !cap_flag_o);
endmodule

bind pulse_capture_unit capt_checker #(.TB_W(TB_W)) u_chk (.*);

// File: tb/sim_pulse_capture_unit.sv
`timescale 1ns/1ps
module sim_pulse_capture_unit;
    localparam int TB_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pin_i = 1'b0;
    logic [TB_W-1:0] tbase_i = '0;
    logic [2:0]      filt_sel_i = '0;
    logic [1:0]      edge_sel_i = '0;
    logic            flag_clr_i = 1'b0;
    logic [TB_W-1:0] cap_val_o;
    logic            cap_flag_o;
    logic            filt_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    bit              hist [0:17];
    bit              m_filt = 0, m_flag = 0;
    logic [TB_W-1:0] m_val = '0;
    logic [TB_W-1:0] last_tb = '0;
    logic [2:0]      cur_sel = 3'd0;
    logic [1:0]      cur_esel = 2'b11;

    pulse_capture_unit #(.TB_W(TB_W)) u0 (.*);

    always #2.5 clk = ~clk;

    function automatic int width_of(input logic [2:0] s);
        if (s == 3'd0) return 1;
        if (s >= 3'd4) return 16;
        return 1 << s;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic model_edge(input bit p, input bit c, input logic [TB_W-1:0] tb);
        bool_t: begin end
        for (int k = 17; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = p;
        begin
            int  w;
            bit  all;
            w   = width_of(cur_sel);
            all = 1;
            for (int k = 2; k <= w + 1; k++) if (hist[k] == m_filt) all = 0;
            if (all) begin
                m_filt = !m_filt;
                if ((m_filt && cur_esel[0]) || (!m_filt && cur_esel[1])) begin
                    m_val  = tb;
                    m_flag = 1;
                end else if (c) m_flag = 0;
            end else if (c) m_flag = 0;
        end
    endtask

    // Drive at the falling edge, let the rising edge act, compare at the next falling edge.
    task automatic step(input bit p, input bit c);
        logic [TB_W-1:0] tb;
        tb = TB_W'($urandom);
        pin_i      = p;
        flag_clr_i = c;
        tbase_i    = tb;
        filt_sel_i = cur_sel;
        edge_sel_i = cur_esel;
        last_tb    = tb;
        @(posedge clk);
        model_edge(p, c, tb);
        @(negedge clk);
        check((cur_sel == 3'd0) ? "R2 filt_o" : "R3 filt_o", 32'(filt_o), 32'(m_filt));
        check("R7 cap_flag_o", 32'(cap_flag_o), 32'(m_flag));
        check("R5 cap_val_o", 32'(cap_val_o), 32'(m_val));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [TB_W-1:0] saved;
        bit              seen;
        bit              lvl;
        void'($urandom(32'd2024));
        for (int k = 0; k < 18; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        check("R1 filt_o in reset", 32'(filt_o), 32'd0);
        check("R1 cap_flag_o in reset", 32'(cap_flag_o), 32'd0);
        check("R1 cap_val_o in reset", 32'(cap_val_o), 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(0, 0);
        check("R1 idle after reset", 32'({filt_o, cap_flag_o}), 32'd0);

        // R2: bypass latency of three edges, with capture of the timebase
        cur_sel = 3'd0; cur_esel = 2'b11;
        step(1, 0); step(1, 0);
        check("R2 no change after two edges", 32'(filt_o), 32'd0);
        step(1, 0);
        check("R2 change on third edge", 32'(filt_o), 32'd1);
        check("R5 value from update edge", 32'(cap_val_o), 32'(last_tb));

        // R7: clear, then clear coinciding with an event
        step(1, 1);
        check("R7 flag cleared", 32'(cap_flag_o), 32'd0);
        step(0, 0); step(0, 0); step(0, 1);
        check("R7 event wins over clear", 32'(cap_flag_o), 32'd1);
        saved = last_tb;
        check("R5 falling capture value", 32'(cap_val_o), 32'(saved));

        // R8: overwrite while flag still set
        step(1, 0); step(1, 0); step(1, 0);
        check("R8 overwrite value", 32'(cap_val_o), 32'(last_tb));
        check("R8 flag still set", 32'(cap_flag_o), 32'd1);

        // R6: capture disabled, then wrong direction only
        step(1, 1);
        saved = cap_val_o;
        cur_esel = 2'b00;
        for (int i = 0; i < 6; i++) step(0, 0);
        check("R6 filt moved", 32'(filt_o), 32'd0);
        check("R6 value kept, none", 32'(cap_val_o), 32'(saved));
        check("R6 flag kept, none", 32'(cap_flag_o), 32'd0);
        cur_esel = 2'b01;
        for (int i = 0; i < 6; i++) step(1, 0);
        check("R5 rise enabled", 32'(cap_flag_o), 32'd1);
        step(1, 1);
        saved = cap_val_o;
        for (int i = 0; i < 6; i++) step(0, 0);
        check("R6 value kept, fall disabled", 32'(cap_val_o), 32'(saved));
        check("R6 flag kept, fall disabled", 32'(cap_flag_o), 32'd0);

        // R4 and R3: width 4 rejects a three-cycle pulse, passes at edge W+2
        cur_sel = 3'd2; cur_esel = 2'b11;
        seen = 0;
        for (int i = 0; i < 3; i++) begin step(1, 0); seen |= filt_o; end
        for (int i = 0; i < 20; i++) begin step(0, 0); seen |= filt_o; end
        check("R4 short pulse rejected", 32'(seen), 32'd0);
        for (int i = 0; i < 5; i++) step(1, 0);
        check("R3 not yet at edge W+1", 32'(filt_o), 32'd0);
        step(1, 0);
        check("R3 change at edge W+2", 32'(filt_o), 32'd1);

        // Random segments over all width codes
        lvl = 1;
        for (int seg = 0; seg < 16; seg++) begin
            for (int i = 0; i < 20; i++) step(lvl, 0);
            cur_sel  = 3'($urandom_range(0, 7));
            cur_esel = 2'($urandom_range(0, 3));
            for (int n = 0; n < 40; n++) begin
                int hold;
                lvl  = ~lvl;
                hold = $urandom_range(1, 20);
                for (int i = 0; i < hold; i++) begin
                    if ($urandom_range(0, 7) == 0) cur_esel = 2'($urandom_range(0, 3));
                    step(lvl, ($urandom_range(0, 15) == 0));
                end
            end
        end

        done = 1;
        summary();
    end
endmodule